// File: doc/BRIEF.md
# Vector Register Masked Writeback Unit

This block owns a bank of vector registers (16 registers of 64 elements, each element 64 bits wide by default). It takes a stream of per-element results from an upstream execution pipe and commits them to one destination register. The upstream pipe supplies one result per cycle. A programmable length and an optional per-element mask decide which elements are written. An operation class decides how the two 32-bit halves of each written element are put together.

Software-visible setup is two registers. The first is a 7-bit length, where values above 64 are treated as 64. The second is a 64-bit mask. Both are loaded through simple write strobes while the unit is idle. A start pulse latches the destination, the second-source register, the class, the mask enable and the mask polarity. The unit then walks element indices upward, one per cycle, and asks for the result of each index. It raises a one-cycle done pulse when the walk ends. A combinational read port lets the surrounding datapath, or a bench, inspect any element.

Top module: `vwb_top`

## Requirements
- R1: After reset, busy, done and elem_req are low, the length register holds 0 and the mask register holds all zeros.
- R2: A stored length above 64 acts as 64. A length of 0 writes no element, and done pulses in the first cycle after the start is accepted.
- R3: Elements whose index is at or above the effective length keep their previous contents.
- R4: With use_mask high, element i (mask bit i, bit 0 for element 0) is written only when that bit equals mask_pol. With use_mask low, every element below the length is written.
- R5: Class code 0 (low-half) writes bits 31:0 from the result and keeps the old bits 63:32 of the element.
- R6: Class code 1 (logical) writes bits 31:0 from the result and takes bits 63:32 from the same element of the second-source register, as it stood before that cycle's write.
- R7: Class codes 2 and 3 (full) write all 64 bits from the result.
- R8: In the k-th cycle after the start edge (k = 1..L), elem_req is high and elem_idx equals k-1. busy stays high over those cycles. done is a single-cycle pulse in cycle L+1.
- R9: While busy, a start pulse, a length write and a mask write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Load the length register |
| len_wdata | input | 7 | New length value (0..127) |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 64 | New mask value, bit i for element i |
| start | input | 1 | Begin a writeback walk (taken when idle) |
| dst_reg | input | 4 | Destination register number |
| src2_reg | input | 4 | Second-source register for the logical class |
| op_class | input | 2 | 0 low-half, 1 logical, 2/3 full |
| use_mask | input | 1 | Enable mask gating |
| mask_pol | input | 1 | Mask bit value that allows a write |
| elem_req | output | 1 | A result is consumed this cycle |
| elem_idx | output | 6 | Index of the element being processed |
| elem_result | input | 64 | Result for elem_idx, valid while elem_req |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| rd_reg | input | 4 | Inspection read register number |
| rd_idx | input | 6 | Inspection read element index |
| rd_data | output | 64 | Inspection read data |

## Verification
The hardest situation to reach from the ports is configuration traffic, or a second start, arriving in the middle of a walk. This traffic must leave no trace, and that is only visible through what later walks do. The stimulus fires a start, a length write and a mask write while busy. It checks that no second done appears and that the other register is untouched. The next walks are then checked against the old length and mask. Lengths above 64, a length of 0 and a logical walk whose second source is its own destination are directed. These are mixed with seeded random walks over all classes and both mask polarities.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  localparam int unsigned VWB_REGS   = 16;
  localparam int unsigned VWB_ELEMS  = 64;
  localparam int unsigned VWB_ELEM_W = 64;

  typedef enum logic [1:0] {
    CLS_LOW   = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_FULL  = 2'd2,
    CLS_WIDE  = 2'd3
  } op_class_e;
endpackage

// File: rtl/vwb_config.sv
module vwb_config #(
  parameter int unsigned NUM_ELEMS = 64,
  localparam int unsigned LEN_W    = $clog2(NUM_ELEMS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 len_wr,
  input  logic [LEN_W-1:0]     len_wdata,
  input  logic                 mask_wr,
  input  logic [NUM_ELEMS-1:0] mask_wdata,
  output logic [LEN_W-1:0]     eff_len,
  output logic [NUM_ELEMS-1:0] mask_q
);
  logic [LEN_W-1:0] len_q;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    return (raw > LEN_W'(NUM_ELEMS)) ? LEN_W'(NUM_ELEMS) : raw;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      if (len_wr && !busy)  len_q  <= len_wdata;
      if (mask_wr && !busy) mask_q <= mask_wdata;
    end
  end

  assign eff_len = clamp_len(len_q);

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(len_q) && $stable(mask_q)));

  assert_reset_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (len_q == '0 && mask_q == '0));
endmodule

// File: rtl/vwb_seq.sv
module vwb_seq
  import vwb_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_ELEMS = 64,
  localparam int unsigned REG_AW   = $clog2(NUM_REGS),
  localparam int unsigned IDX_W    = $clog2(NUM_ELEMS),
  localparam int unsigned LEN_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_AW-1:0] dst_reg,
  input  logic [REG_AW-1:0] src2_reg,
  input  logic [1:0]        op_class,
  input  logic              use_mask,
  input  logic              mask_pol,
  input  logic [LEN_W-1:0]  eff_len,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output logic [REG_AW-1:0] run_dst,
  output logic [REG_AW-1:0] run_src2,
  output op_class_e         run_cls,
  output logic              run_use_mask,
  output logic              run_pol
);
  logic start_ok;
  logic last_hit;

  function automatic logic is_last(input logic [IDX_W-1:0] i, input logic [LEN_W-1:0] len);
    return ({1'b0, i} + LEN_W'(1)) == len;
  endfunction

  assign start_ok = start && !busy;
  assign last_hit = busy && is_last(idx, eff_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      idx          <= '0;
      run_dst      <= '0;
      run_src2     <= '0;
      run_cls      <= CLS_LOW;
      run_use_mask <= 1'b0;
      run_pol      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        run_dst      <= dst_reg;
        run_src2     <= src2_reg;
        run_cls      <= op_class_e'(op_class);
        run_use_mask <= use_mask;
        run_pol      <= mask_pol;
        idx          <= '0;
        if (eff_len == '0) done <= 1'b1;
        else               busy <= 1'b1;
      end else if (busy) begin
        if (last_hit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx == $past(idx) + IDX_W'(1)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> (done && !busy));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!busy && !done));
endmodule

// File: rtl/vwb_lane.sv
module vwb_lane
  import vwb_pkg::*;
#(
  parameter int unsigned NUM_ELEMS = 64,
  parameter int unsigned ELEM_W    = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_ELEMS),
  localparam int unsigned LEN_W    = IDX_W + 1,
  localparam int unsigned HALF_W   = ELEM_W / 2
) (
  input  logic                 active,
  input  logic [IDX_W-1:0]     idx,
  input  logic [LEN_W-1:0]     eff_len,
  input  logic [NUM_ELEMS-1:0] mask_q,
  input  logic                 use_mask,
  input  logic                 mask_pol,
  input  op_class_e            cls,
  input  logic [ELEM_W-1:0]    result,
  input  logic [ELEM_W-1:0]    old_data,
  input  logic [ELEM_W-1:0]    src2_data,
  output logic                 wr_en,
  output logic [ELEM_W-1:0]    wr_data
);
  function automatic logic elem_enable(input logic [IDX_W-1:0] i,
                                       input logic [LEN_W-1:0] len,
                                       input logic [NUM_ELEMS-1:0] m,
                                       input logic um, input logic pol);
    logic in_len;
    in_len = ({1'b0, i} < len);
    return in_len && (!um || (m[i] == pol));
  endfunction

  function automatic logic [ELEM_W-1:0] form_element(input op_class_e c,
                                                     input logic [ELEM_W-1:0] r,
                                                     input logic [ELEM_W-1:0] old_v,
                                                     input logic [ELEM_W-1:0] s2);
    logic [ELEM_W-1:0] v;
    unique case (c)
      CLS_LOW:   v = {old_v[ELEM_W-1:HALF_W], r[HALF_W-1:0]};
      CLS_LOGIC: v = {s2[ELEM_W-1:HALF_W],    r[HALF_W-1:0]};
      default:   v = r;
    endcase
    return v;
  endfunction

  assign wr_en   = active && elem_enable(idx, eff_len, mask_q, use_mask, mask_pol);
  assign wr_data = form_element(cls, result, old_data, src2_data);
endmodule

// File: rtl/vwb_regfile.sv
module vwb_regfile #(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_ELEMS = 64,
  parameter int unsigned ELEM_W    = 64,
  localparam int unsigned REG_AW   = $clog2(NUM_REGS),
  localparam int unsigned IDX_W    = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic [REG_AW-1:0] a_reg,
  input  logic [REG_AW-1:0] b_reg,
  input  logic [IDX_W-1:0]  ab_idx,
  output logic [ELEM_W-1:0] a_data,
  output logic [ELEM_W-1:0] b_data,
  input  logic [REG_AW-1:0] x_reg,
  input  logic [IDX_W-1:0]  x_idx,
  output logic [ELEM_W-1:0] x_data
);
  logic [ELEM_W-1:0] bank_ab [NUM_REGS];
  logic [ELEM_W-1:0] bank_x  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    logic [ELEM_W-1:0] cells [NUM_ELEMS];
    always_ff @(posedge clk) begin
      if (we && (wr_reg == REG_AW'(g))) cells[wr_idx] <= wr_data;
    end
    assign bank_ab[g] = cells[ab_idx];
    assign bank_x[g]  = cells[x_idx];
  end

  assign a_data = bank_ab[a_reg];
  assign b_data = bank_ab[b_reg];
  assign x_data = bank_x[x_reg];
endmodule

// File: rtl/vwb_top.sv
module vwb_top
  import vwb_pkg::*;
#(
  parameter int unsigned NUM_REGS  = VWB_REGS,
  parameter int unsigned NUM_ELEMS = VWB_ELEMS,
  parameter int unsigned ELEM_W    = VWB_ELEM_W,
  localparam int unsigned REG_AW   = $clog2(NUM_REGS),
  localparam int unsigned IDX_W    = $clog2(NUM_ELEMS),
  localparam int unsigned LEN_W    = IDX_W + 1,
  localparam int unsigned HALF_W   = ELEM_W / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 len_wr,
  input  logic [LEN_W-1:0]     len_wdata,
  input  logic                 mask_wr,
  input  logic [NUM_ELEMS-1:0] mask_wdata,
  input  logic                 start,
  input  logic [REG_AW-1:0]    dst_reg,
  input  logic [REG_AW-1:0]    src2_reg,
  input  logic [1:0]           op_class,
  input  logic                 use_mask,
  input  logic                 mask_pol,
  output logic                 elem_req,
  output logic [IDX_W-1:0]     elem_idx,
  input  logic [ELEM_W-1:0]    elem_result,
  output logic                 busy,
  output logic                 done,
  input  logic [REG_AW-1:0]    rd_reg,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [ELEM_W-1:0]    rd_data
);
  logic [LEN_W-1:0]     eff_len;
  logic [NUM_ELEMS-1:0] mask_q;
  logic [REG_AW-1:0]    run_dst, run_src2;
  op_class_e            run_cls;
  logic                 run_use_mask, run_pol;
  logic [ELEM_W-1:0]    old_data, src2_data, wr_data;
  logic                 wr_en;

  vwb_config #(.NUM_ELEMS(NUM_ELEMS)) u_config (
    .clk, .rst_n, .busy, .len_wr, .len_wdata, .mask_wr, .mask_wdata,
    .eff_len, .mask_q
  );

  vwb_seq #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS)) u_seq (
    .clk, .rst_n, .start, .dst_reg, .src2_reg, .op_class, .use_mask, .mask_pol,
    .eff_len, .busy, .done, .idx(elem_idx), .run_dst, .run_src2, .run_cls,
    .run_use_mask, .run_pol
  );

  vwb_lane #(.NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_lane (
    .active(busy), .idx(elem_idx), .eff_len, .mask_q, .use_mask(run_use_mask),
    .mask_pol(run_pol), .cls(run_cls), .result(elem_result), .old_data,
    .src2_data, .wr_en, .wr_data
  );

  vwb_regfile #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .ELEM_W(ELEM_W)) u_regs (
    .clk, .we(wr_en), .wr_reg(run_dst), .wr_idx(elem_idx), .wr_data,
    .a_reg(run_dst), .b_reg(run_src2), .ab_idx(elem_idx),
    .a_data(old_data), .b_data(src2_data),
    .x_reg(rd_reg), .x_idx(rd_idx), .x_data(rd_data)
  );

  assign elem_req = busy;

  assert_no_write_beyond_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, elem_idx} < eff_len));

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_use_mask) |-> (mask_q[elem_idx] == run_pol));

  assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_cls == CLS_LOW) |-> (wr_data[ELEM_W-1:HALF_W] == old_data[ELEM_W-1:HALF_W]));

  assert_upper_from_src2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_cls == CLS_LOGIC) |-> (wr_data[ELEM_W-1:HALF_W] == src2_data[ELEM_W-1:HALF_W]));

  assert_full_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_cls[1]) |-> (wr_data == elem_result));

  assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_req);
endmodule

// File: tb/test_vwb_top.sv
module test_vwb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0;
  logic [6:0]  len_wdata = '0;
  logic        mask_wr = 1'b0;
  logic [63:0] mask_wdata = '0;
  logic        start = 1'b0;
  logic [3:0]  dst_reg = '0, src2_reg = '0;
  logic [1:0]  op_class = '0;
  logic        use_mask = 1'b0, mask_pol = 1'b0;
  logic        elem_req;
  logic [5:0]  elem_idx;
  logic [63:0] elem_result;
  logic        busy, done;
  logic [3:0]  rd_reg = '0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] run_key = '0;
  logic [63:0] ref_mem [16][64];
  bit          known [16];
  int          len_model = 0;
  logic [63:0] mask_model = '0;

  always #2 clk = ~clk;

  vwb_top i_vwb_top (
    .clk, .rst_n, .len_wr, .len_wdata, .mask_wr, .mask_wdata, .start, .dst_reg,
    .src2_reg, .op_class, .use_mask, .mask_pol, .elem_req, .elem_idx, .elem_result,
    .busy, .done, .rd_reg, .rd_idx, .rd_data
  );

  function automatic logic [63:0] elem_val(input logic [63:0] key, input logic [5:0] i);
    logic [31:0] lo, hi;
    lo = key[31:0] ^ ({26'd0, i} * 32'h9E37_79B9);
    hi = key[63:32] + {26'd0, i} * 32'h0101_0003;
    return {hi, lo};
  endfunction

  always_comb elem_result = elem_val(run_key, elem_idx);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_len(input int v);
    @(negedge clk); len_wr = 1'b1; len_wdata = 7'(v);
    @(negedge clk); len_wr = 1'b0;
    len_model = v;
  endtask

  task automatic set_mask(input logic [63:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = m;
    @(negedge clk); mask_wr = 1'b0;
    mask_model = m;
  endtask

  task automatic verify_reg(input int r, input int elen, input int cls,
                            input bit um, input bit pol);
    string tag;
    if (!known[r]) return;
    for (int i = 0; i < 64; i++) begin
      rd_reg = 4'(r); rd_idx = 6'(i);
      #1;
      if (i >= elen) tag = "R3 beyond length";
      else if (um && (mask_model[i] != pol)) tag = "R4 masked off";
      else if (cls == 0) tag = "R5 low-half";
      else if (cls == 1) tag = "R6 logical";
      else tag = "R7 full";
      check(tag, rd_data, ref_mem[r][i]);
    end
  endtask

  task automatic run_op(input int dst, input int src2, input int cls, input bit um,
                        input bit pol, input logic [63:0] key, input bit interfere);
    int n, reqs, elen, other;
    bit seen;
    string ttag;
    logic [63:0] r, up;
    elen  = (len_model > 64) ? 64 : len_model;
    other = (dst + 1) % 16;
    ttag  = (len_model == 0 || len_model > 64) ? "R2 length edge timing" : "R8 timing";
    @(negedge clk);
    run_key = key; start = 1'b1; dst_reg = 4'(dst); src2_reg = 4'(src2);
    op_class = 2'(cls); use_mask = um; mask_pol = pol;
    @(negedge clk);
    start = 1'b0;
    n = 1; seen = 0; reqs = 0;
    while (!seen && n <= 70) begin
      if (done) seen = 1;
      else begin
        if (elem_req) begin
          reqs++;
          check("R8 element index", 64'(elem_idx), 64'(n - 1));
        end
        if (interfere && n == 2) begin
          start = 1'b1; dst_reg = 4'(other); op_class = 2'd2; use_mask = 1'b0;
          len_wr = 1'b1; len_wdata = 7'd5; mask_wr = 1'b1; mask_wdata = ~mask_model;
        end else if (interfere && n == 3) begin
          start = 1'b0; len_wr = 1'b0; mask_wr = 1'b0;
        end
        @(negedge clk);
        n++;
      end
    end
    check({ttag, " done cycle"}, 64'(n), 64'(elen + 1));
    check("R8 request count", 64'(reqs), 64'(elen));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(interfere ? "R9 no second done" : "R8 single done pulse", 64'(done), 64'd0);
    end
    for (int i = 0; i < elen; i++) begin
      if (!um || mask_model[i] == pol) begin
        r  = elem_val(key, 6'(i));
        up = ref_mem[src2][i];
        case (cls)
          0:       ref_mem[dst][i] = {ref_mem[dst][i][63:32], r[31:0]};
          1:       ref_mem[dst][i] = {up[63:32], r[31:0]};
          default: ref_mem[dst][i] = r;
        endcase
      end
    end
    if (!um && cls >= 2 && elen == 64) known[dst] = 1;
    verify_reg(dst, elen, cls, um, pol);
    if (interfere) verify_reg(other, 0, 2, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len_pick, cls, src2;
    logic [63:0] key, m;
    void'($urandom(32'd20240611));
    for (int r = 0; r < 16; r++) known[r] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 done after reset", 64'(done), 64'd0);
    check("R1 elem_req after reset", 64'(elem_req), 64'd0);
    // R1: reset length is 0, so a walk right away finishes at once (R2)
    run_op(0, 0, 2, 0, 0, 64'h1111, 0);

    // Fill every register with a full-width unmasked walk
    set_len(64);
    for (int r = 0; r < 16; r++)
      run_op(r, r, 2, 0, 0, {$urandom, $urandom}, 0);

    // R2: length above 64 acts as 64
    set_len(127);
    run_op(3, 4, 2, 0, 0, 64'hA5A5_0000_5A5A_0001, 0);
    set_len(65);
    run_op(5, 6, 0, 0, 0, 64'h0F0F_1234_F0F0_4321, 0);

    // R4: alternating mask, both polarities
    set_len(40);
    set_mask(64'hAAAA_AAAA_AAAA_AAAA);
    run_op(7, 8, 2, 1, 1, 64'hDEAD_BEEF_0000_0007, 0);
    run_op(8, 9, 0, 1, 0, 64'hCAFE_F00D_0000_0008, 0);

    // R6: logical with second source equal to destination
    set_len(33);
    run_op(9, 9, 1, 0, 0, 64'h7777_8888_9999_AAAA, 0);

    // R9: start, length and mask writes while busy are ignored
    set_len(20);
    set_mask(64'h0000_0000_FFFF_0F0F);
    run_op(10, 11, 1, 1, 1, 64'h1357_9BDF_2468_ACE0, 1);
    // following walk must still see length 20 and the old mask (R9)
    run_op(12, 13, 2, 1, 1, 64'h0246_8ACE_1357_9BDF, 0);

    // Seeded random walks
    for (int t = 0; t < 40; t++) begin
      len_pick = $urandom % 8;
      case (len_pick)
        0: set_len(0);
        1: set_len(1);
        2: set_len(64);
        3: set_len(65 + $urandom % 63);
        default: set_len(2 + $urandom % 62);
      endcase
      m = {$urandom, $urandom};
      set_mask(m);
      cls  = $urandom % 4;
      src2 = $urandom % 16;
      key  = {$urandom, $urandom};
      run_op($urandom % 16, src2, cls, 1'($urandom), 1'($urandom), key, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule